// File: doc/BRIEF.md
# Clear-on-Read Result Register Slave

This block is a memory-mapped slave that holds one result word for an internal producer and a bus master to share. The producer is a state machine elsewhere on the chip. It hands over a new result through a request/data pair. The top bit of the word tells the master whether the word holds fresh data. When the master reads the word, that flag drops to zero, so the same result is never taken twice.

Internal updates and bus accesses must never touch the register in the same cycle. A small arbiter handles this. When the producer asks for an update, the arbiter moves to a load state for one cycle. In that cycle it raises waitrequest, so no bus command can be accepted while the register changes. After each load it returns to the open state for at least one cycle, so a producer that keeps requesting cannot lock the bus out.

Read data comes back on a fixed one-cycle path marked by readdatavalid. A new read can be accepted in the same cycle that the previous read's data is presented, so a stream of reads runs at one per cycle.

The arbiter has two states. ST_OPEN accepts bus commands and drives waitrequest low. ST_LOAD writes the producer data and drives waitrequest and upd_ack high. It has two transitions. OPEN goes to LOAD when upd_req is high. LOAD goes back to OPEN unconditionally.

Top module: `cor_result_slave`

## Requirements
- R1: After reset the result word is zero, waitrequest is low and readdatavalid is low. A read of word address 0 then returns 0.
- R2: A read is accepted in a cycle where read is high, write is low and waitrequest is low. Exactly one cycle after that, readdatavalid is high for one cycle. readdata then holds the result word as it was at the accepting edge, with bit 31 unchanged. readdatavalid is never high otherwise.
- R3: An accepted read of word address 0 clears bit 31 of the result word. Bits 30..0 keep their value.
- R4: An accepted read of any address other than 0 returns zero. It leaves the result word untouched, including bit 31.
- R5: An accepted write to word address 0 replaces all 32 bits with writedata. A write to any other address has no effect. A write never raises readdatavalid. If read and write are high together, the command is treated as a write only.
- R6: When upd_req is high in the open state, the next cycle is a load cycle. In that cycle waitrequest and upd_ack are both high. At the end of that cycle the result word takes upd_data, including bit 31 as given by the producer.
- R7: A read or write held by the master during a load cycle is not accepted in that cycle. It has no effect until waitrequest is low, and then it completes against the newly loaded word.
- R8: After every load cycle, waitrequest is low for at least one cycle, even when upd_req stays high.
- R9: readdatavalid is never high in the cycle in which waitrequest falls.
- R10: Reads held high on consecutive open cycles are each accepted. Their data returns in order, one per cycle. The second read of address 0 sees bit 31 already cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| address | input | ADDR_W | Word address; only 0 is decoded |
| read | input | 1 | Read command |
| write | input | 1 | Write command |
| writedata | input | DATA_W | Write data |
| waitrequest | output | 1 | High while the register is being loaded by the producer |
| readdata | output | DATA_W | Returned read data |
| readdatavalid | output | 1 | Marks the cycle carrying readdata |
| upd_req | input | 1 | Producer requests a load |
| upd_data | input | DATA_W | Word to load |
| upd_ack | output | 1 | High in the cycle the load takes place |

## Verification
The bench sweeps sixteen data words. Each word alternates bit 31 and comes from multiplying a constant by the index. Each word goes through load, a read of a foreign address, and two reads of address 0. This separates three faults: a clear that also hits low bits, a clear triggered by foreign addresses, and a flag that never clears. A write sweep follows, with writes to other addresses mixed in, to show that only address 0 is decoded. Commands are also held across a load cycle. That shows whether a stalled read returns the pre-load or the post-load word, and whether a stalled write is lost. Finally, a three-read burst confirms the one-per-cycle ordering and the mid-burst clear.

// File: rtl/cor_pkg.sv
package cor_pkg;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_LOAD = 1'b1
    } arb_state_t;

endpackage

// File: rtl/cor_update_arbiter.sv
module cor_update_arbiter
    import cor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_req,
    output logic stall_o,
    output logic grant_o
);

    arb_state_t state_q;
    arb_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (upd_req) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_OPEN;
            default: state_d = ST_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // outputs, decoded from the registered state only
    always_comb begin
        stall_o = 1'b0;
        grant_o = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                stall_o = 1'b0;
                grant_o = 1'b0;
            end
            ST_LOAD: begin
                stall_o = 1'b1;
                grant_o = 1'b1;
            end
            default: begin
                stall_o = 1'b0;
                grant_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cor_result_reg.sv
module cor_result_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    output logic [DATA_W-1:0] value_o
);

    localparam int FLAG_BIT = DATA_W - 1;

    logic [DATA_W-1:0] word_q;

    // producer load outranks bus write, which outranks the read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_en) begin
            word_q <= load_data;
        end else if (wr_en) begin
            word_q <= wr_data;
        end else if (clr_en) begin
            word_q[FLAG_BIT] <= 1'b0;
        end
    end

    assign value_o = word_q;

endmodule

// File: rtl/cor_read_return.sv
module cor_read_return #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              hit,
    input  logic [DATA_W-1:0] value,
    output logic              rdv_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              rdv_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rdv_q <= accept;
            if (accept) rdata_q <= hit ? value : '0;
        end
    end

    assign rdv_o   = rdv_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/cor_result_slave.sv
module cor_result_slave #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic              write,
    input  logic [DATA_W-1:0] writedata,
    output logic              waitrequest,
    output logic [DATA_W-1:0] readdata,
    output logic              readdatavalid,
    input  logic              upd_req,
    input  logic [DATA_W-1:0] upd_data,
    output logic              upd_ack
);

    localparam logic [ADDR_W-1:0] RESULT_ADDR = '0;

    logic              stall;
    logic              grant;
    logic              hit;
    logic              acc_rd;
    logic              acc_wr;
    logic [DATA_W-1:0] result_q;

    assign hit    = (address == RESULT_ADDR);
    assign acc_wr = write && !stall;
    assign acc_rd = read && !write && !stall;

    cor_update_arbiter i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_req (upd_req),
        .stall_o (stall),
        .grant_o (grant)
    );

    cor_result_reg #(.DATA_W(DATA_W)) i_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (grant),
        .load_data (upd_data),
        .wr_en     (acc_wr && hit),
        .wr_data   (writedata),
        .clr_en    (acc_rd && hit),
        .value_o   (result_q)
    );

    cor_read_return #(.DATA_W(DATA_W)) i_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (acc_rd),
        .hit     (hit),
        .value   (result_q),
        .rdv_o   (readdatavalid),
        .rdata_o (readdata)
    );

    assign waitrequest = stall;
    assign upd_ack     = grant;

endmodule

// File: rtl/cor_result_slave_chk.sv
module cor_result_slave_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] address,
    input logic              read,
    input logic              write,
    input logic              waitrequest,
    input logic              readdatavalid,
    input logic              upd_ack,
    input logic [DATA_W-1:0] result_q
);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !write && !waitrequest) |=> readdatavalid); // R2
    AST_NO_STRAY_RDV: assert property (@(posedge clk) disable iff (!rst_n)
        readdatavalid |-> $past(read && !write && !waitrequest)); // R2
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !write && !waitrequest && address == '0) |=> !result_q[DATA_W-1]); // R3
    AST_ACK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ack |-> waitrequest); // R6
    AST_BUS_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
        waitrequest |=> !waitrequest); // R8
    AST_NO_FALL_WITH_RDV: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(waitrequest) && readdatavalid)); // R9

endmodule

bind cor_result_slave cor_result_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .address       (address),
    .read          (read),
    .write         (write),
    .waitrequest   (waitrequest),
    .readdatavalid (readdatavalid),
    .upd_ack       (upd_ack),
    .result_q      (result_q)
);

// File: tb/test_cor_result_slave.sv
module test_cor_result_slave;

    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] address = '0;
    logic          read = 1'b0;
    logic          write = 1'b0;
    logic [DW-1:0] writedata = '0;
    logic          waitrequest;
    logic [DW-1:0] readdata;
    logic          readdatavalid;
    logic          upd_req = 1'b0;
    logic [DW-1:0] upd_data = '0;
    logic          upd_ack;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mdl = '0;

    always #2 clk = ~clk;

    cor_result_slave #(.DATA_W(DW), .ADDR_W(AW)) i_cor_result_slave (
        .clk(clk), .rst_n(rst_n), .address(address), .read(read), .write(write),
        .writedata(writedata), .waitrequest(waitrequest), .readdata(readdata),
        .readdatavalid(readdatavalid), .upd_req(upd_req), .upd_data(upd_data),
        .upd_ack(upd_ack)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read one word; the expected value is derived from the model
    task automatic bus_read(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] exp;
        @(negedge clk);
        address = a; read = 1'b1;
        while (waitrequest) @(negedge clk);
        exp = (a == 0) ? mdl : '0;
        if (a == 0) mdl[DW-1] = 1'b0;
        @(negedge clk);
        read = 1'b0;
        check({req, " rdv"}, {31'b0, readdatavalid}, 32'd1);
        check({req, " data"}, readdata, exp);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        address = a; write = 1'b1; writedata = d;
        while (waitrequest) @(negedge clk);
        if (a == 0) mdl = d;
        @(negedge clk);
        write = 1'b0;
        check("R5 no rdv on write", {31'b0, readdatavalid}, 32'd0);
    endtask

    task automatic produce(input logic [DW-1:0] d);
        @(negedge clk);
        upd_req = 1'b1; upd_data = d;
        @(negedge clk);
        check("R6 stall in load", {31'b0, waitrequest}, 32'd1);
        check("R6 ack in load", {31'b0, upd_ack}, 32'd1);
        upd_req = 1'b0;
        mdl = d;
        @(negedge clk);
        check("R8 open after load", {31'b0, waitrequest}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] exp_q [3];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wait", {31'b0, waitrequest}, 32'd0);
        check("R1 rdv", {31'b0, readdatavalid}, 32'd0);
        bus_read(0, "R1 reset word");

        // load / foreign read / clearing reads sweep
        for (int k = 0; k < 16; k++) begin
            d = 32'h9E37_79B9 * (k + 1);
            d[DW-1] = k[0];
            produce(d);
            bus_read(AW'(k % 15 + 1), "R4 foreign read");
            bus_read(0, "R2 first read");
            bus_read(0, "R3 flag cleared");
        end

        // write sweep with foreign writes mixed in
        for (int k = 0; k < 16; k++) begin
            d = ~(32'h0F1E_2D3C * (k + 3)) ^ 32'(k);
            bus_write(0, d);
            bus_write(AW'(k % 15 + 1), ~d);
            bus_read(0, "R5 write readback");
        end

        // read held across a load cycle
        @(negedge clk);
        upd_req = 1'b1; upd_data = 32'hC0DE_0001;
        @(negedge clk);
        upd_req = 1'b0; read = 1'b1; address = '0;
        mdl = 32'hC0DE_0001;
        @(negedge clk);
        check("R7 stalled read no rdv", {31'b0, readdatavalid}, 32'd0);
        check("R7 stall released", {31'b0, waitrequest}, 32'd0);
        @(negedge clk);
        read = 1'b0;
        check("R7 read after load", readdata, mdl);
        check("R9 rdv", {31'b0, readdatavalid}, 32'd1);
        mdl[DW-1] = 1'b0;

        // write held across a load cycle, with the request kept high
        @(negedge clk);
        upd_req = 1'b1; upd_data = 32'hFFFF_0000;
        @(negedge clk);
        write = 1'b1; address = '0; writedata = 32'h1234_5678;
        @(negedge clk);
        check("R8 gap despite req", {31'b0, waitrequest}, 32'd0);
        upd_req = 1'b0;
        @(negedge clk);
        write = 1'b0;
        mdl = 32'h1234_5678;
        @(negedge clk);
        bus_read(0, "R7 stalled write lands");

        // three reads back to back
        produce(32'h8000_00A5);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) begin
                check("R10 burst rdv", {31'b0, readdatavalid}, 32'd1);
                check("R10 burst data", readdata, exp_q[i-1]);
            end
            if (i < 3) begin
                read = 1'b1; address = '0;
                exp_q[i] = mdl;
                mdl[DW-1] = 1'b0;
            end else begin
                read = 1'b0;
            end
            @(negedge clk);
        end
        check("R10 burst end", {31'b0, readdatavalid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule